// File: doc/BRIEF.md
# Sixteen-Bit Integer ALU with Condition Flags

This block is the execute stage of a small accumulator CPU. Each operation is started by a one-cycle `start` pulse. The pulse carries an 8-bit operation code, a destination operand `opa`, a second operand `opb` and the stored carry flag. For the immediate forms of an operation, the decoder of the CPU places the immediate word on `opb`, and the ALU treats it the same way as a register operand.

The block returns the following:
- a 16-bit result, plus a high result word when the operation is a multiply;
- write strobes for the destination and for the high register;
- fresh zero, negative, carry and overflow flags;
- a one-cycle `done` pulse.

Add, subtract, their carry-chained forms, multiply and the bitwise operations finish in one cycle. Divide and modulo run a restoring shift-subtract sequence of one quotient bit per cycle. Compare and test change only the flags.

The controller has three states:
- `S_IDLE` accepts `start`. A non-zero divide or modulo moves to `S_DIV_RUN`. Every other code stays in `S_IDLE` and registers its outputs at once.
- `S_DIV_RUN` performs one divider step per cycle. After the last step it moves to `S_DIV_DONE`.
- `S_DIV_DONE` publishes the quotient or remainder and then returns to `S_IDLE`.

Top module: `alu16_core`

## Requirements
- R1: After reset, `done`, `wr_en`, `wr_hi` and `busy` are low, and all four flags are 0.
- R2: Opcodes 0x1E and 0x23 give `opa+opb`. Opcodes 0x28 and 0x30 give `opa+opb+carry_in`. `flag_c` is the carry out of bit 15, and `flag_v` is signed overflow. The plain forms ignore `carry_in`.
- R3: Opcodes 0x1F and 0x24 give `opa-opb`. Opcodes 0x29 and 0x31 give `opa-opb-carry_in`. `flag_c` is 1 when a borrow occurs, and `flag_v` is signed overflow.
- R4: For every 16-bit result, `flag_z` is 1 exactly when the result is zero, and `flag_n` equals result bit 15.
- R5: Opcodes 0x20 and 0x25 form the unsigned 32-bit product. The low word goes to `result` and the high word to `result_hi`, with `wr_en` and `wr_hi` both set. `flag_z` is 1 when the product is zero, and `flag_n` equals product bit 31. `flag_c` and `flag_v` are 1 when the high word is non-zero.
- R6: Opcodes 0x21 and 0x26 return the unsigned quotient; 0x22 and 0x27 return the remainder, with C and V cleared. `done` rises 18 falling edges after the start pulse, and `busy` is high in between.
- R7: A divide or modulo with `opb` equal to 0 finishes after one cycle. It gives `wr_en` low, V set, and Z, N and C cleared.
- R8: Opcodes 0x32 and 0x37 give AND, 0x33 and 0x38 give OR, 0x34 gives XOR, and 0x35 gives `~opa`. C and V are cleared.
- R9: TEST (0x36) sets Z and N from `opa&opb`. CMP (0x5A) and CMP_IMM (0x5B) set all four flags the way R3 does without carry. All three keep `wr_en` low.
- R10: A single-cycle operation raises `done` on the first falling edge after its start edge. `wr_en` and `wr_hi` are never high without `done`.
- R11: An opcode outside the map gives `done` with `wr_en` low, and leaves all four flags unchanged.
- R12: A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opcode | input | 8 | Operation code |
| opa | input | 16 | Destination / first operand |
| opb | input | 16 | Second operand or immediate |
| carry_in | input | 1 | Stored carry flag |
| busy | output | 1 | Divide sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Write `result` to the destination |
| wr_hi | output | 1 | Write `result_hi` to the high register |
| result | output | 16 | Result word (low product word for multiply) |
| result_hi | output | 16 | High product word |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow flag |
| flag_v | output | 1 | Overflow / divide-fault flag |

## Verification
A vector table applies the four corner words 0x0000, 0x7FFF, 0x8000 and 0xFFFF to every opcode family. These vectors separate carry-out from signed overflow and borrow from overflow. They also show whether `carry_in` takes part in the plain and chained forms, and whether the high product word is routed correctly.

A random pass draws each operand from either the corner words or uniform values. It compares every legal opcode against an arithmetic model in the bench and exposes quotient and remainder errors.

Directed sequences cover the following:
- divide latency and the `busy` window;
- a `start` pulse issued during a divide;
- divide by zero;
- an illegal opcode that follows a compare, which shows that the flags are held.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_MUL, K_DIV, K_MOD,
        K_AND, K_OR, K_XOR, K_NOT, K_TEST, K_CMP, K_BAD
    } op_kind_e;

    typedef enum logic [1:0] {
        S_IDLE, S_DIV_RUN, S_DIV_DONE
    } alu_state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
    import alu16_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind,
    output logic       use_cin
);
    always_comb begin
        use_cin = 1'b0;
        unique case (opcode)
            8'h1E, 8'h23: kind = K_ADD;
            8'h1F, 8'h24: kind = K_SUB;
            8'h28, 8'h30: begin kind = K_ADD; use_cin = 1'b1; end
            8'h29, 8'h31: begin kind = K_SUB; use_cin = 1'b1; end
            8'h20, 8'h25: kind = K_MUL;
            8'h21, 8'h26: kind = K_DIV;
            8'h22, 8'h27: kind = K_MOD;
            8'h32, 8'h37: kind = K_AND;
            8'h33, 8'h38: kind = K_OR;
            8'h34:        kind = K_XOR;
            8'h35:        kind = K_NOT;
            8'h36:        kind = K_TEST;
            8'h5A, 8'h5B: kind = K_CMP;
            default:      kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  op_kind_e    kind,
    input  logic        use_cin,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic        carry_in,
    output logic [W-1:0] res,
    output logic [W-1:0] res_hi,
    output alu_flags_t  flags,
    output logic        wr,
    output logic        wr_hi
);
    localparam int MSB = W - 1;

    logic          cin_eff;
    logic [W:0]    sum_w;
    logic [W:0]    dif_w;
    logic [2*W-1:0] prod_w;

    assign cin_eff = use_cin & carry_in;
    assign sum_w   = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin_eff};
    assign dif_w   = {1'b0, opa} - {1'b0, opb} - {{W{1'b0}}, cin_eff};
    assign prod_w  = opa * opb;

    always_comb begin
        res    = '0;
        res_hi = '0;
        wr     = 1'b1;
        wr_hi  = 1'b0;
        flags  = '0;
        unique case (kind)
            K_ADD: begin
                res     = sum_w[W-1:0];
                flags.c = sum_w[W];
                flags.v = (opa[MSB] == opb[MSB]) && (sum_w[MSB] != opa[MSB]);
            end
            K_SUB, K_CMP: begin
                res     = dif_w[W-1:0];
                flags.c = dif_w[W];
                flags.v = (opa[MSB] != opb[MSB]) && (dif_w[MSB] != opa[MSB]);
                wr      = (kind == K_SUB);
            end
            K_MUL: begin
                res    = prod_w[W-1:0];
                res_hi = prod_w[2*W-1:W];
                wr_hi  = 1'b1;
            end
            K_AND:  res = opa & opb;
            K_OR:   res = opa | opb;
            K_XOR:  res = opa ^ opb;
            K_NOT:  res = ~opa;
            K_TEST: begin
                res = opa & opb;
                wr  = 1'b0;
            end
            default: wr = 1'b0;
        endcase
        if (kind == K_MUL) begin
            flags.z = (prod_w == '0);
            flags.n = prod_w[2*W-1];
            flags.c = |prod_w[2*W-1:W];
            flags.v = |prod_w[2*W-1:W];
        end else begin
            flags.z = (res == '0);
            flags.n = res[MSB];
        end
    end
endmodule

// File: rtl/alu16_divider.sv
module alu16_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    logic [W:0]   rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvs_q;
    logic [W:0]   shifted;
    logic [W:0]   trial;

    assign shifted = {rem_q[W-1:0], quo_q[W-1]};
    assign trial   = shifted - {1'b0, dvs_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
        end else if (step) begin
            if (!trial[W]) begin
                rem_q <= trial;
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted;
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q[W-1:0];

    // R6
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q < {1'b0, dvs_q}));
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [7:0]   opcode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         carry_in,
    output logic         busy,
    output logic         done,
    output logic         wr_en,
    output logic         wr_hi,
    output logic [W-1:0] result,
    output logic [W-1:0] result_hi,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_c,
    output logic         flag_v
);
    localparam int             CW       = $clog2(W + 1);
    localparam logic [CW-1:0]  CNT_INIT = CW'(W);

    op_kind_e   kind;
    logic       use_cin;
    logic [W-1:0] a_res, a_hi;
    alu_flags_t a_flags;
    logic       a_wr, a_wrhi;
    logic [W-1:0] quo, rem;

    alu_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic       mod_q;
    logic       accept, is_div, div_zero, load, step;

    logic       done_q, wr_q, wrhi_q;
    logic [W-1:0] res_q, hi_q;
    alu_flags_t flag_q;

    alu16_decode u_dec (
        .opcode  (opcode),
        .kind    (kind),
        .use_cin (use_cin)
    );

    alu16_arith #(.W(W)) u_arith (
        .kind     (kind),
        .use_cin  (use_cin),
        .opa      (opa),
        .opb      (opb),
        .carry_in (carry_in),
        .res      (a_res),
        .res_hi   (a_hi),
        .flags    (a_flags),
        .wr       (a_wr),
        .wr_hi    (a_wrhi)
    );

    alu16_divider #(.W(W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .dividend  (opa),
        .divisor   (opb),
        .quotient  (quo),
        .remainder (rem)
    );

    assign accept   = (state_q == S_IDLE) && start;
    assign is_div   = (kind == K_DIV) || (kind == K_MOD);
    assign div_zero = (opb == '0);
    assign load     = accept && is_div && !div_zero;
    assign step     = (state_q == S_DIV_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (load) state_d = S_DIV_RUN;
            S_DIV_RUN:  if (cnt_q == CW'(1)) state_d = S_DIV_DONE;
            S_DIV_DONE: state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            mod_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cnt_q <= CNT_INIT;
                mod_q <= (kind == K_MOD);
            end else if (step) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            wrhi_q <= 1'b0;
            res_q  <= '0;
            hi_q   <= '0;
            flag_q <= '0;
        end else begin
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            wrhi_q <= 1'b0;
            if (state_q == S_DIV_DONE) begin
                done_q   <= 1'b1;
                wr_q     <= 1'b1;
                res_q    <= mod_q ? rem : quo;
                flag_q.z <= ((mod_q ? rem : quo) == '0);
                flag_q.n <= mod_q ? rem[W-1] : quo[W-1];
                flag_q.c <= 1'b0;
                flag_q.v <= 1'b0;
            end else if (accept && !load) begin
                done_q <= 1'b1;
                if (is_div) begin
                    flag_q <= '{z: 1'b0, n: 1'b0, c: 1'b0, v: 1'b1};
                end else if (kind != K_BAD) begin
                    wr_q   <= a_wr;
                    wrhi_q <= a_wrhi;
                    res_q  <= a_res;
                    hi_q   <= a_hi;
                    flag_q <= a_flags;
                end
            end
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign wr_en     = wr_q;
    assign wr_hi     = wrhi_q;
    assign result    = res_q;
    assign result_hi = hi_q;
    assign flag_z    = flag_q.z;
    assign flag_n    = flag_q.n;
    assign flag_c    = flag_q.c;
    assign flag_v    = flag_q.v;

    // R10
    write_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q || wrhi_q) |-> done_q);

    // R5
    high_write_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrhi_q |-> wr_q);

    // R11
    illegal_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_BAD) |=> (done_q && !wr_q && $stable(flag_q)));

    // R12
    quiet_while_dividing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DIV_RUN) |-> !done_q);
endmodule

// File: tb/alu16_core_tb.sv
module alu16_core_tb_top;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
        logic        wr;
        logic        wrhi;
        logic [15:0] res;
        logic [15:0] hi;
        logic [3:0]  flg;
    } vec_t;

    localparam int NV = 27;
    localparam logic [78:0] VECS [0:NV-1] = '{
        {8'h1E, 16'h7FFF, 16'h0001, 1'b0, 1'b1, 1'b0, 16'h8000, 16'h0000, 4'b0101},
        {8'h1E, 16'hFFFF, 16'h0001, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 4'b1010},
        {8'h1E, 16'h0001, 16'h0001, 1'b1, 1'b1, 1'b0, 16'h0002, 16'h0000, 4'b0000},
        {8'h23, 16'h1234, 16'h0001, 1'b0, 1'b1, 1'b0, 16'h1235, 16'h0000, 4'b0000},
        {8'h1F, 16'h0000, 16'h0001, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 4'b0110},
        {8'h1F, 16'h8000, 16'h0001, 1'b0, 1'b1, 1'b0, 16'h7FFF, 16'h0000, 4'b0001},
        {8'h24, 16'h0005, 16'h0005, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 4'b1000},
        {8'h28, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 4'b1010},
        {8'h29, 16'h0005, 16'h0005, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 4'b0110},
        {8'h30, 16'h0001, 16'h0001, 1'b1, 1'b1, 1'b0, 16'h0003, 16'h0000, 4'b0000},
        {8'h31, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 4'b0110},
        {8'h20, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1, 16'h0001, 16'hFFFE, 4'b0111},
        {8'h25, 16'h0100, 16'h0100, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h0001, 4'b0011},
        {8'h20, 16'h0000, 16'h1234, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h0000, 4'b1000},
        {8'h21, 16'h0064, 16'h0007, 1'b1, 1'b1, 1'b0, 16'h000E, 16'h0000, 4'b0000},
        {8'h22, 16'h0064, 16'h0007, 1'b0, 1'b1, 1'b0, 16'h0002, 16'h0000, 4'b0000},
        {8'h26, 16'h1234, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'b0001},
        {8'h27, 16'h00FF, 16'h0010, 1'b0, 1'b1, 1'b0, 16'h000F, 16'h0000, 4'b0000},
        {8'h32, 16'hF0F0, 16'h0F0F, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 4'b1000},
        {8'h33, 16'h8000, 16'h0001, 1'b0, 1'b1, 1'b0, 16'h8001, 16'h0000, 4'b0100},
        {8'h34, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 4'b1000},
        {8'h35, 16'h0000, 16'h1234, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 4'b0100},
        {8'h36, 16'h8000, 16'h8001, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'b0100},
        {8'h37, 16'hFFFF, 16'h8000, 1'b0, 1'b1, 1'b0, 16'h8000, 16'h0000, 4'b0100},
        {8'h38, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 4'b1000},
        {8'h5A, 16'h0001, 16'h0002, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'b0110},
        {8'h5B, 16'h8000, 16'h7FFF, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'b0001}
    };

    localparam int NOPS = 22;
    localparam logic [7:0] LEGAL [0:NOPS-1] = '{
        8'h1E, 8'h1F, 8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'h28,
        8'h29, 8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h5A
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        carry_in = 1'b0;
    logic        busy, done, wr_en, wr_hi, flag_z, flag_n, flag_c, flag_v;
    logic [15:0] result, result_hi;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    alu16_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .opa       (opa),
        .opb       (opb),
        .carry_in  (carry_in),
        .busy      (busy),
        .done      (done),
        .wr_en     (wr_en),
        .wr_hi     (wr_hi),
        .result    (result),
        .result_hi (result_hi),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_c    (flag_c),
        .flag_v    (flag_v)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b,
                          input logic cin, output int lat);
        @(negedge clk);
        opcode = op; opa = a; opb = b; carry_in = cin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // reference model: {wr, wrhi, res, hi, z, n, c, v}
    function automatic logic [37:0] model(input logic [7:0] op, input logic [15:0] a,
                                          input logic [15:0] b, input logic cin);
        logic [15:0] r, h;
        logic w, wh, z, n, c, v;
        int unsigned sa, sb, full;
        logic [31:0] p;
        w = 1'b1; wh = 1'b0; r = '0; h = '0; c = 1'b0; v = 1'b0;
        sa = a; sb = b;
        case (op)
            8'h1E, 8'h23, 8'h28, 8'h30: begin
                full = sa + sb + ((op == 8'h28 || op == 8'h30) ? cin : 0);
                r = full[15:0]; c = (full > 32'hFFFF);
                v = (a[15] == b[15]) && (r[15] != a[15]);
            end
            8'h1F, 8'h24, 8'h29, 8'h31, 8'h5A: begin
                full = sb + ((op == 8'h29 || op == 8'h31) ? cin : 0);
                r = 16'(sa - full); c = (full > sa);
                v = (a[15] != b[15]) && (r[15] != a[15]);
                w = (op != 8'h5A);
            end
            8'h20, 8'h25: begin
                p = sa * sb; r = p[15:0]; h = p[31:16]; wh = 1'b1;
                c = (h != 0); v = c;
            end
            8'h21, 8'h26, 8'h22, 8'h27: begin
                if (b == 0) begin w = 1'b0; v = 1'b1; end
                else r = (op == 8'h21 || op == 8'h26) ? 16'(sa / sb) : 16'(sa % sb);
            end
            8'h32, 8'h37: r = a & b;
            8'h33, 8'h38: r = a | b;
            8'h34: r = a ^ b;
            8'h35: r = ~a;
            8'h36: begin r = a & b; w = 1'b0; end
            default: w = 1'b0;
        endcase
        if (wh) begin z = ({h, r} == 0); n = h[15]; end
        else begin z = (r == 0); n = r[15]; end
        if (!w && (op == 8'h21 || op == 8'h22 || op == 8'h26 || op == 8'h27)) begin
            z = 1'b0; n = 1'b0;
        end
        return {w, wh, r, h, z, n, c, v};
    endfunction

    function automatic logic [15:0] pick(input int sel);
        case (sel % 6)
            0: return 16'h0000;
            1: return 16'h7FFF;
            2: return 16'h8000;
            3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h1E, 8'h23, 8'h28, 8'h30: return "R2";
            8'h1F, 8'h24, 8'h29, 8'h31: return "R3";
            8'h20, 8'h25: return "R5";
            8'h21, 8'h22, 8'h26, 8'h27: return "R6";
            8'h36, 8'h5A, 8'h5B: return "R9";
            default: return "R8";
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        if (!ended) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int lat;
        vec_t vv;
        logic [37:0] m;
        logic [15:0] ra, rb;
        logic [7:0] rop;
        int ndone;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "done", {31'b0, done}, 0);
        chk("R1", "busy", {31'b0, busy}, 0);
        chk("R1", "wr_en/wr_hi", {30'b0, wr_en, wr_hi}, 0);
        chk("R1", "flags", {28'b0, flag_z, flag_n, flag_c, flag_v}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vv = vec_t'(VECS[i]);
            run_op(vv.op, vv.a, vv.b, vv.cin, lat);
            chk(tag_of(vv.op), "done", {31'b0, done}, 1);
            chk(vv.op == 8'h26 ? "R7" : tag_of(vv.op), "wr_en", {31'b0, wr_en}, {31'b0, vv.wr});
            chk("R5", "wr_hi", {31'b0, wr_hi}, {31'b0, vv.wrhi});
            if (vv.wr) chk(tag_of(vv.op), "result", {16'b0, result}, {16'b0, vv.res});
            if (vv.wrhi) chk("R5", "result_hi", {16'b0, result_hi}, {16'b0, vv.hi});
            chk(vv.op == 8'h26 ? "R7" : "R4", "flags",
                {28'b0, flag_z, flag_n, flag_c, flag_v}, {28'b0, vv.flg});
        end

        // R10 single-cycle latency
        run_op(8'h33, 16'h0F00, 16'h00F0, 1'b0, lat);
        chk("R10", "latency", 32'(lat), 1);

        // R6 divide latency and busy window
        @(negedge clk);
        opcode = 8'h21; opa = 16'h00FF; opb = 16'h0003; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6", "busy", {31'b0, busy}, 1);
        // R12 start during divide is ignored
        opcode = 8'h1E; opa = 16'h1111; opb = 16'h2222; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ndone = 0;
        lat = 2;
        for (int k = 0; k < 30; k++) begin
            if (done) begin
                ndone++;
                chk("R6", "div latency", 32'(lat), 18);
                chk("R12", "result", {16'b0, result}, 32'h0055);
            end
            @(negedge clk);
            lat++;
        end
        chk("R12", "done count", 32'(ndone), 1);
        chk("R6", "busy after", {31'b0, busy}, 0);

        // R11 illegal opcode keeps flags
        run_op(8'h5A, 16'h0001, 16'h0002, 1'b0, lat);
        run_op(8'h00, 16'h0000, 16'h0000, 1'b1, lat);
        chk("R11", "done", {31'b0, done}, 1);
        chk("R11", "wr_en", {31'b0, wr_en}, 0);
        chk("R11", "flags", {28'b0, flag_z, flag_n, flag_c, flag_v}, 32'b0110);

        // R7 divide by zero via modulo register form
        run_op(8'h22, 16'h8000, 16'h0000, 1'b0, lat);
        chk("R7", "latency", 32'(lat), 1);
        chk("R7", "flags", {28'b0, flag_z, flag_n, flag_c, flag_v}, 32'b0001);

        // random pass against the model
        for (int i = 0; i < 300; i++) begin
            rop = LEGAL[$urandom % NOPS];
            ra = pick(int'($urandom % 12));
            rb = pick(int'($urandom % 12));
            if (i % 5 == 0) rop = 8'h5B;
            m = model(rop == 8'h5B ? 8'h5A : rop, ra, rb, 1'($urandom));
            m = model(rop == 8'h5B ? 8'h5A : rop, ra, rb, 1'b1);
            run_op(rop, ra, rb, 1'b1, lat);
            chk(tag_of(rop), "rand wr", {30'b0, wr_en, wr_hi}, {30'b0, m[37:36]});
            if (m[37]) chk(tag_of(rop), "rand result", {16'b0, result}, {16'b0, m[35:20]});
            if (m[36]) chk("R5", "rand hi", {16'b0, result_hi}, {16'b0, m[19:4]});
            chk("R4", "rand flags", {28'b0, flag_z, flag_n, flag_c, flag_v}, {28'b0, m[3:0]});
        end

        ended = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule